// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two parallel buses, called A and B, through a pair of storage registers. Each of the two transfer directions has its own register and its own capture clock. A-side data goes into the A-to-B register and B-side data goes into the B-to-A register. Capture happens on every rising edge of that direction's clock, whatever the output controls are doing.

The bus that is driven carries one of two things. It can carry the live value from the opposite bus, or it can carry the value held in that direction's register. A select input for each direction makes this choice.

One active-low enable and one direction input decide which bus is driven, if any. Since there are no real tristate pins, each bus appears as three vectors: an input, an output and a per-bit output enable. The pad ring above this block turns those into bidirectional pins. An output vector that is not driven reads as zero.

Top module: `regbus_xcvr`

## Requirements
- R1: Asserting `rst_n` low clears both storage registers to all zeros, with no clock edge needed. After reset, a stored-data path drives zero.
- R2: On every rising edge of `clk_ab`, `a_in` is captured into the A-to-B register. This happens for every setting of `out_en_n`, `dir_sel` and both selects.
- R3: On every rising edge of `clk_ba`, `b_in` is captured into the B-to-A register. This happens for every setting of `out_en_n`, `dir_sel` and both selects.
- R4: While `out_en_n` is 1, `a_oe` and `b_oe` are both all zeros.
- R5: While `out_en_n` is 0 and `dir_sel` is 0, `a_oe` is all ones and `b_oe` is all zeros.
- R6: While `out_en_n` is 0 and `dir_sel` is 1, `b_oe` is all ones and `a_oe` is all zeros.
- R7: While B is driven, `b_out` equals the live `a_in` when `sel_ab_stored` is 0. It equals the A-to-B register when `sel_ab_stored` is 1.
- R8: While A is driven, `a_out` equals the live `b_in` when `sel_ba_stored` is 0. It equals the B-to-A register when `sel_ba_stored` is 1.
- R9: `a_oe` and `b_oe` are never both non-zero at the same time.
- R10: While neither clock has a rising edge, both registers keep their contents, whatever `a_in` and `b_in` do.
- R11: The output vector of a bus that is not driven is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst_n | input | 1 | Asynchronous active-low clear of both registers |
| out_en_n | input | 1 | Active-low output enable |
| dir_sel | input | 1 | 0: drive A from the B side, 1: drive B from the A side |
| sel_ab_stored | input | 1 | 1: B carries the stored A-to-B value, 0: live A |
| sel_ba_stored | input | 1 | 1: A carries the stored B-to-A value, 0: live B |
| a_in | input | W | Value seen on bus A |
| a_out | output | W | Value driven onto bus A |
| a_oe | output | W | Per-bit drive enable of bus A |
| b_in | input | W | Value seen on bus B |
| b_out | output | W | Value driven onto bus B |
| b_oe | output | W | Per-bit drive enable of bus B |

## Verification
The bench captures data with the outputs isolated and also with the outputs pointed the other way. A design that gated capture with the enable or the direction would then leave stale data in the register, and that shows up later on the stored path. After each capture, it sweeps all sixteen combinations of enable, direction and the two selects. Swapped selects, swapped directions, or a live path wired to the wrong bus all give a wrong value or a wrong enable pattern in some combination. The bench also changes both bus inputs while both clocks are quiet. A register that followed its input without a clock edge would then show the new value instead of the held one. Finally, it reads the stored paths straight after reset, which catches a reset value other than zero.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_TO_A = 2'd1,
    ROUTE_TO_B = 2'd2
  } route_e;

  // Which bus is driven, from the active-low enable and the direction input.
  function automatic route_e decode_route(input logic en_n, input logic dir);
    if (en_n) return ROUTE_NONE;
    return dir ? ROUTE_TO_B : ROUTE_TO_A;
  endfunction

  // Choose between the live value and the stored value.
  function automatic logic [63:0] pick_src(input logic use_stored,
                                           input logic [63:0] live,
                                           input logic [63:0] stored);
    return use_stored ? stored : live;
  endfunction

endpackage

// File: rtl/xcvr_store_reg.sv
module xcvr_store_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // Loads on every rising edge; nothing gates the load.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import xcvr_pkg::*;
(
  input  logic   out_en_n,
  input  logic   dir_sel,
  output route_e route,
  output logic   drive_a,
  output logic   drive_b
);
  always_comb begin
    route   = decode_route(out_en_n, dir_sel);
    drive_a = (route == ROUTE_TO_A);
    drive_b = (route == ROUTE_TO_B);
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         drive,
  input  logic         use_stored,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] bus_out,
  output logic [W-1:0] bus_oe
);
  localparam int PW = 64;
  logic [PW-1:0] live_x, stored_x, chosen_x;

  always_comb begin
    live_x   = '0;
    stored_x = '0;
    live_x[W-1:0]   = live;
    stored_x[W-1:0] = stored;
    chosen_x = pick_src(use_stored, live_x, stored_x);
  end

  // One enable per bit; the bit's output is forced to zero when it is not driven.
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bus_oe[i]  = drive;
    assign bus_out[i] = drive & chosen_x[i];
  end

  if (PW > W) begin : g_unused
    logic unused_hi;
    assign unused_hi = ^chosen_x[PW-1:W];
  end
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst_n,
  input  logic         out_en_n,
  input  logic         dir_sel,
  input  logic         sel_ab_stored,
  input  logic         sel_ba_stored,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  // Named internal events, visible to the bound checker.
  logic [W-1:0] stored_ab;
  logic [W-1:0] stored_ba;
  route_e       route;
  logic         drive_a;
  logic         drive_b;

  xcvr_store_reg #(.W(W)) u_reg_ab (
    .clk(clk_ab), .rst_n(rst_n), .d(a_in), .q(stored_ab)
  );

  xcvr_store_reg #(.W(W)) u_reg_ba (
    .clk(clk_ba), .rst_n(rst_n), .d(b_in), .q(stored_ba)
  );

  xcvr_drive_ctrl u_ctrl (
    .out_en_n(out_en_n), .dir_sel(dir_sel),
    .route(route), .drive_a(drive_a), .drive_b(drive_b)
  );

  // Path onto bus B, carrying A-side data.
  xcvr_path #(.W(W)) u_to_b (
    .drive(drive_b), .use_stored(sel_ab_stored),
    .live(a_in), .stored(stored_ab),
    .bus_out(b_out), .bus_oe(b_oe)
  );

  // Path onto bus A, carrying B-side data.
  xcvr_path #(.W(W)) u_to_a (
    .drive(drive_a), .use_stored(sel_ba_stored),
    .live(b_in), .stored(stored_ba),
    .bus_out(a_out), .bus_oe(a_oe)
  );

  logic unused_route;
  assign unused_route = ^route;
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst_n,
  input logic         out_en_n,
  input logic         dir_sel,
  input logic         sel_ab_stored,
  input logic         sel_ba_stored,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe,
  input logic [W-1:0] stored_ab,
  input logic [W-1:0] stored_ba
);
  // R2: the A-to-B register follows the A input across each of its own edges
  a_r2_capture_ab: assert property (@(posedge clk_ab) disable iff (!rst_n)
    1'b1 |=> stored_ab == $past(a_in));

  // R3: the B-to-A register follows the B input across each of its own edges
  a_r3_capture_ba: assert property (@(posedge clk_ba) disable iff (!rst_n)
    1'b1 |=> stored_ba == $past(b_in));

  // R4, R11: isolation leaves both buses undriven and at zero
  a_r4_isolated: assert property (@(posedge clk_ab) disable iff (!rst_n)
    out_en_n |-> (a_oe == '0 && b_oe == '0 && a_out == '0 && b_out == '0));

  // R5
  a_r5_drive_a: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!out_en_n && !dir_sel) |-> (&a_oe && b_oe == '0));

  // R6
  a_r6_drive_b: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!out_en_n && dir_sel) |-> (&b_oe && a_oe == '0));

  // R7: stored A-to-B data reaches bus B
  a_r7_stored_b: assert property (@(posedge clk_ab) disable iff (!rst_n)
    (!out_en_n && dir_sel && sel_ab_stored) |-> b_out == stored_ab);

  // R8: live B data reaches bus A
  a_r8_live_a: assert property (@(posedge clk_ba) disable iff (!rst_n)
    (!out_en_n && !dir_sel && !sel_ba_stored) |-> a_out == b_in);

  // R9
  a_r9_one_side: assert property (@(posedge clk_ab) disable iff (!rst_n)
    !((|a_oe) && (|b_oe)));
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.W(W)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
  .out_en_n(out_en_n), .dir_sel(dir_sel),
  .sel_ab_stored(sel_ab_stored), .sel_ba_stored(sel_ba_stored),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
  .b_out(b_out), .b_oe(b_oe),
  .stored_ab(stored_ab), .stored_ba(stored_ba)
);

// File: tb/tb_regbus_xcvr.sv
`timescale 1ns/1ps
module tb_regbus_xcvr;
  localparam int W = 8;

  logic tb_clk = 1'b0;
  always #4 tb_clk = ~tb_clk;   // 125 MHz timebase

  logic clk_ab = 1'b0, clk_ba = 1'b0, rst_n = 1'b0;
  logic out_en_n = 1'b1, dir_sel = 1'b0, sel_ab_stored = 1'b0, sel_ba_stored = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  int n_cmp = 0, n_bad = 0;
  logic [W-1:0] m_ab = '0, m_ba = '0;   // bench model of the two registers

  regbus_xcvr #(.W(W)) dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst_n(rst_n),
    .out_en_n(out_en_n), .dir_sel(dir_sel),
    .sel_ab_stored(sel_ab_stored), .sel_ba_stored(sel_ba_stored),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_ctrl(input logic [3:0] c);
    {out_en_n, dir_sel, sel_ab_stored, sel_ba_stored} = c;
    #1;
  endtask

  // Rising edge on one or both capture clocks, placed between timebase edges.
  task automatic pulse(input logic do_ab, input logic do_ba);
    @(posedge tb_clk); #1;
    clk_ab = do_ab; clk_ba = do_ba;
    if (do_ab) m_ab = a_in;
    if (do_ba) m_ba = b_in;
    #3; clk_ab = 1'b0; clk_ba = 1'b0; #1;
  endtask

  // Recompute every output from the requirements and compare.
  task automatic check_all();
    logic da, db;
    logic [W-1:0] ea, eb;
    da = !out_en_n && !dir_sel;
    db = !out_en_n && dir_sel;
    ea = da ? (sel_ba_stored ? m_ba : b_in) : '0;
    eb = db ? (sel_ab_stored ? m_ab : a_in) : '0;
    cmp(out_en_n ? "R4" : (dir_sel ? "R6" : "R5"), "a_oe", a_oe, {W{da}});
    cmp(out_en_n ? "R4" : (dir_sel ? "R6" : "R5"), "b_oe", b_oe, {W{db}});
    cmp(da ? "R8" : "R11", "a_out", a_out, ea);
    cmp(db ? "R7" : "R11", "b_out", b_out, eb);
    n_cmp++;
    if ((|a_oe) && (|b_oe)) begin
      n_bad++;
      $display("FAIL R9 both driven: actual a_oe=%h b_oe=%h expected one zero", a_oe, b_oe);
    end
  endtask

  initial begin
    #1600000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    a_in = 8'h5A; b_in = 8'hC3;
    #20; rst_n = 1'b1; #5;
    // R1: both registers are zero after reset, seen through the stored paths
    set_ctrl(4'b0110); cmp("R1", "b_out stored", b_out, '0);
    set_ctrl(4'b0001); cmp("R1", "a_out stored", a_out, '0);
    check_all();

    for (int i = 0; i < 24; i++) begin
      logic [3:0] cap_ctrl;
      cap_ctrl = 4'(i * 5 + 3);
      a_in = 8'(i * 37 + 11) ^ 8'hA5;
      b_in = 8'(i * 91 + 7) ^ 8'h3C;
      set_ctrl(cap_ctrl);
      pulse(i % 3 != 1, i % 3 != 0);
      // R2 / R3: read back what was just captured, whatever controls were set during capture
      set_ctrl(4'b0110); cmp("R2", "b_out stored after clk_ab", b_out, m_ab);
      set_ctrl(4'b0001); cmp("R3", "a_out stored after clk_ba", a_out, m_ba);
      for (int c = 0; c < 16; c++) begin
        set_ctrl(4'(c));
        check_all();
      end
    end

    // R10: capture while isolated, then move the inputs with both clocks quiet
    set_ctrl(4'b1000);
    a_in = 8'h81; b_in = 8'h18;
    pulse(1'b1, 1'b1);
    a_in = 8'h7E; b_in = 8'hE7;
    repeat (3) @(posedge tb_clk);
    #2;
    set_ctrl(4'b0110); cmp("R10", "held A-to-B", b_out, 8'h81);
    set_ctrl(4'b0001); cmp("R10", "held B-to-A", a_out, 8'h18);
    set_ctrl(4'b1110); check_all();

    // R1: an asynchronous reset in mid-run clears both registers
    rst_n = 1'b0; #3; m_ab = '0; m_ba = '0; rst_n = 1'b1; #2;
    set_ctrl(4'b0110); cmp("R1", "b_out after reset", b_out, '0);
    set_ctrl(4'b0001); cmp("R1", "a_out after reset", a_out, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule